// File: doc/BRIEF.md
# Polyphase scaler phase generator

This block drives one axis of a polyphase image scaler. A 16-bit scale ratio gives the destination size over the source size in unsigned fixed point with 14 fraction bits. From it the block derives the reciprocal source step per output pixel, with 16 fraction bits. On every output-pixel strobe it adds that step to a fractional accumulator. It then reports how many source pixels the filter window must move (0, 1 or 2) and an 8-bit sub-pixel phase, which is the top byte of the accumulator fraction.

A start pulse at the head of each line or frame clears the accumulator. A blanking flag marks data such as vertical-blanking payload, which moves through one source pixel per output pixel, ignores the ratio and leaves the accumulator alone. The block also holds a coefficient store of 256 phases by TAPS signed 10-bit taps (9 fraction bits). Software loads it through three write registers. The row for the current phase is presented beside the phase, so the filter gets phase and weights in the same cycle.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is held and after its release, `adv_o`, `phase_o` and `out_vld_o` are 0.
- R2: The step is floor(2^30 / ratio), a value with 16 fraction bits. A strobe with no blanking and no start adds the step to the fraction. In the next cycle `out_vld_o` is 1, `adv_o` is the integer part of the sum and `phase_o` is bits [15:8] of the new fraction.
- R3: A ratio below 0x2000 is treated as 0x2000, which gives a step of exactly 2.0. A strobe then always shows `adv_o` = 2. `adv_o` never shows 3.
- R4: A start without a strobe clears the fraction. In the next cycle `adv_o` and `phase_o` are 0 and `out_vld_o` is 0.
- R5: A start and a strobe in the same cycle act as the first pixel of a new line. The step is added to a fraction of zero.
- R6: In a cycle with neither start nor strobe, `adv_o` and `phase_o` hold their values in the next cycle and `out_vld_o` is 0.
- R7: A strobe with `blank_i` high gives `adv_o` = 1 and `phase_o` = 0 in the next cycle and leaves the fraction unchanged. The ratio has no effect on this result.
- R8: With `sw_wr_i` high, select 0 loads the row write address from data bits [7:0]. Select 1 stages taps 0..TAPS/2-1. Select 2 writes the row {data taps, staged taps} at that address and then adds 1 to the address, wrapping from 255 to 0. Tap k of a row occupies bits [10k+9:10k].
- R9: `coef_o` always holds the stored row whose index equals the `phase_o` shown in the same cycle, with tap k at bits [10k+9:10k].
- R10: A write with select 3 changes neither the stored rows nor the write address nor the staged taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_i | input | RATIO_W | Destination/source ratio, RATIO_FRAC fraction bits |
| start_i | input | 1 | Line or frame start, clears the accumulator |
| px_strobe_i | input | 1 | One output pixel is produced this cycle |
| blank_i | input | 1 | Current pixel is blanking data and is not scaled |
| sw_wr_i | input | 1 | Software register write |
| sw_sel_i | input | 2 | Register select: 0 address, 1 low taps, 2 high taps and commit |
| sw_wdata_i | input | (TAPS/2)*COEF_W | Software write data |
| adv_o | output | 2 | Source pixels to advance for this output pixel |
| phase_o | output | PHASE_W | Sub-pixel phase |
| out_vld_o | output | 1 | adv_o and phase_o belong to a strobe from the previous cycle |
| coef_o | output | TAPS*COEF_W | Coefficient row for phase_o |

## Verification
The key collision is a start pulse arriving in the same cycle as a pixel strobe. That pixel must be computed from a cleared fraction and not from the fraction left by the previous line. The bench causes this collision on purpose, both in directed cases and in random line starts where the strobe is drawn independently of the start. It also combines start with blanking. Each result is compared against a reference accumulator kept in the bench that applies the clear before the add. The row shown on `coef_o` is checked against a bench copy of the coefficient store on every pixel, including rows written across the address wrap.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;
    // software register selects
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_NONE = 2'd3
    } sw_sel_e;
endpackage

// File: rtl/scl_step_recip.sv
`timescale 1ns/1ps
// Combinational reciprocal: step = 2^(RATIO_FRAC+ACC_FRAC) / ratio, ratio clamped below 0.5
module scl_step_recip #(
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 14,
    parameter int ACC_FRAC   = 16,
    parameter int STEP_W     = 18
) (
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [STEP_W-1:0]  step_o
);
    localparam int NUM_BITS = RATIO_FRAC + ACC_FRAC + 1;
    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(1) << (RATIO_FRAC - 1);

    logic [RATIO_W-1:0] div;
    logic [RATIO_W:0]   rem;
    logic [STEP_W-1:0]  quo;
    logic               take;

    always_comb begin
        div  = (ratio_i < MIN_RATIO) ? MIN_RATIO : ratio_i;
        rem  = '0;
        quo  = '0;
        take = 1'b0;
        // restoring division; numerator has only its top bit set
        for (int i = NUM_BITS - 1; i >= 0; i--) begin
            rem  = {rem[RATIO_W-1:0], (i == NUM_BITS - 1)};
            take = (rem >= {1'b0, div});
            if (take) begin
                rem = rem - {1'b0, div};
            end
            quo = {quo[STEP_W-2:0], take};
        end
        step_o = quo;
    end
endmodule

// File: rtl/scl_phase_accum.sv
`timescale 1ns/1ps
module scl_phase_accum #(
    parameter int ACC_FRAC = 16,
    parameter int STEP_W   = 18,
    parameter int PHASE_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       strobe_i,
    input  logic                       blank_i,
    input  logic [STEP_W-1:0]          step_i,
    output logic [STEP_W-ACC_FRAC-1:0] adv_o,
    output logic [PHASE_W-1:0]         phase_o,
    output logic                       vld_o,
    output logic [PHASE_W-1:0]         phase_nxt_o
);
    localparam int ADV_W = STEP_W - ACC_FRAC;

    typedef struct packed {
        logic [ACC_FRAC-1:0] frac;
        logic [ADV_W-1:0]    adv;
        logic [PHASE_W-1:0]  phase;
        logic                vld;
    } acc_st_t;

    acc_st_t             st_d, st_q;
    logic [ACC_FRAC-1:0] base;
    logic [STEP_W-1:0]   sum;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        base     = start_i ? '0 : st_q.frac;
        sum      = {{ADV_W{1'b0}}, base} + step_i;
        if (start_i) begin
            st_d.frac  = '0;
            st_d.adv   = '0;
            st_d.phase = '0;
        end
        if (strobe_i) begin
            st_d.vld = 1'b1;
            if (blank_i) begin
                st_d.frac  = base;
                st_d.adv   = ADV_W'(1);
                st_d.phase = '0;
            end else begin
                st_d.frac  = sum[ACC_FRAC-1:0];
                st_d.adv   = sum[STEP_W-1:ACC_FRAC];
                st_d.phase = sum[ACC_FRAC-1 -: PHASE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign adv_o       = st_q.adv;
    assign phase_o     = st_q.phase;
    assign vld_o       = st_q.vld;
    assign phase_nxt_o = st_d.phase;
endmodule

// File: rtl/scl_coef_ram.sv
`timescale 1ns/1ps
module scl_coef_ram
    import scl_pkg::*;
#(
    parameter int TAPS    = 4,
    parameter int COEF_W  = 10,
    parameter int PHASE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [1:0]                    sel_i,
    input  logic [(TAPS/2)*COEF_W-1:0]    wdata_i,
    input  logic [PHASE_W-1:0]            rd_addr_i,
    output logic [TAPS*COEF_W-1:0]        rd_data_o
);
    localparam int HALF_W = (TAPS / 2) * COEF_W;
    localparam int ROW_W  = TAPS * COEF_W;
    localparam int DEPTH  = 1 << PHASE_W;

    typedef struct packed {
        logic [PHASE_W-1:0] waddr;
        logic [HALF_W-1:0]  stage;
    } wr_st_t;

    wr_st_t             st_d, st_q;
    logic               we;
    logic [ROW_W-1:0]   wrow;
    logic [ROW_W-1:0]   mem [DEPTH];
    logic [ROW_W-1:0]   rd_q;
    logic               unused_addr_bits;

    assign unused_addr_bits = ^wdata_i[HALF_W-1:PHASE_W];

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        wrow = {wdata_i, st_q.stage};
        if (wr_i) begin
            case (sw_sel_e'(sel_i))
                SEL_ADDR: st_d.waddr = wdata_i[PHASE_W-1:0];
                SEL_LOW:  st_d.stage = wdata_i;
                SEL_HIGH: begin
                    we         = 1'b1;
                    st_d.waddr = st_q.waddr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // storage: registered read, old data on a same-row write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[st_q.waddr] <= wrow;
        end
        rd_q <= mem[rd_addr_i];
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen #(
    parameter int TAPS       = 4,
    parameter int COEF_W     = 10,
    parameter int PHASE_W    = 8,
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 14,
    parameter int ACC_FRAC   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [RATIO_W-1:0]            ratio_i,
    input  logic                          start_i,
    input  logic                          px_strobe_i,
    input  logic                          blank_i,
    input  logic                          sw_wr_i,
    input  logic [1:0]                    sw_sel_i,
    input  logic [(TAPS/2)*COEF_W-1:0]    sw_wdata_i,
    output logic [1:0]                    adv_o,
    output logic [PHASE_W-1:0]            phase_o,
    output logic                          out_vld_o,
    output logic [TAPS*COEF_W-1:0]        coef_o
);
    // step never exceeds 2.0, so two integer bits
    localparam int STEP_W = ACC_FRAC + 2;

    logic [STEP_W-1:0]  step;
    logic [PHASE_W-1:0] phase_nxt;

    scl_step_recip #(
        .RATIO_W    (RATIO_W),
        .RATIO_FRAC (RATIO_FRAC),
        .ACC_FRAC   (ACC_FRAC),
        .STEP_W     (STEP_W)
    ) u_recip (
        .ratio_i (ratio_i),
        .step_o  (step)
    );

    scl_phase_accum #(
        .ACC_FRAC (ACC_FRAC),
        .STEP_W   (STEP_W),
        .PHASE_W  (PHASE_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .strobe_i    (px_strobe_i),
        .blank_i     (blank_i),
        .step_i      (step),
        .adv_o       (adv_o),
        .phase_o     (phase_o),
        .vld_o       (out_vld_o),
        .phase_nxt_o (phase_nxt)
    );

    scl_coef_ram #(
        .TAPS    (TAPS),
        .COEF_W  (COEF_W),
        .PHASE_W (PHASE_W)
    ) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (sw_wr_i),
        .sel_i     (sw_sel_i),
        .wdata_i   (sw_wdata_i),
        .rd_addr_i (phase_nxt),
        .rd_data_o (coef_o)
    );
endmodule

// File: rtl/scl_phase_gen_chk.sv
`timescale 1ns/1ps
module scl_phase_gen_chk #(
    parameter int RATIO_W    = 16,
    parameter int RATIO_FRAC = 14,
    parameter int PHASE_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               start_i,
    input logic               px_strobe_i,
    input logic               blank_i,
    input logic [1:0]         adv_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic               out_vld_o
);
    localparam logic [RATIO_W-1:0] LOW_RATIO = RATIO_W'(1) << (RATIO_FRAC - 1);

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px_strobe_i |=> out_vld_o);

    // R6
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_strobe_i |=> !out_vld_o);

    // R3
    adv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> adv_o != 2'd3);

    // R3
    clamp_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_strobe_i && !blank_i && ratio_i < LOW_RATIO) |=> adv_o == 2'd2);

    // R4
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !px_strobe_i) |=> (adv_o == 2'd0 && phase_o == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !px_strobe_i) |=> ($stable(adv_o) && $stable(phase_o)));

    // R7
    blank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_strobe_i && blank_i) |=> (adv_o == 2'd1 && phase_o == '0));
endmodule

bind scl_phase_gen scl_phase_gen_chk #(
    .RATIO_W    (RATIO_W),
    .RATIO_FRAC (RATIO_FRAC),
    .PHASE_W    (PHASE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_i     (ratio_i),
    .start_i     (start_i),
    .px_strobe_i (px_strobe_i),
    .blank_i     (blank_i),
    .adv_o       (adv_o),
    .phase_o     (phase_o),
    .out_vld_o   (out_vld_o)
);

// File: tb/scl_phase_gen_bench.sv
`timescale 1ns/1ps
module scl_phase_gen_bench;
    localparam int TAPS   = 4;
    localparam int COEF_W = 10;
    localparam int HALF_W = (TAPS / 2) * COEF_W;
    localparam int ROW_W  = TAPS * COEF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       ratio = 16'h4000;
    logic              start = 1'b0;
    logic              strobe = 1'b0;
    logic              blank = 1'b0;
    logic              sw_wr = 1'b0;
    logic [1:0]        sw_sel = 2'd0;
    logic [HALF_W-1:0] sw_wdata = '0;
    logic [1:0]        adv;
    logic [7:0]        phase;
    logic              vld;
    logic [ROW_W-1:0]  coef;

    int total = 0;
    int bad   = 0;

    // reference state
    longint           m_frac = 0;
    int               m_adv  = 0;
    int               m_ph   = 0;
    logic [7:0]       m_waddr = '0;
    logic [HALF_W-1:0] m_stage = '0;
    logic [ROW_W-1:0] mem_m [256];

    always #2.5 clk = ~clk;

    scl_phase_gen u_scl_phase_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_i     (ratio),
        .start_i     (start),
        .px_strobe_i (strobe),
        .blank_i     (blank),
        .sw_wr_i     (sw_wr),
        .sw_sel_i    (sw_sel),
        .sw_wdata_i  (sw_wdata),
        .adv_o       (adv),
        .phase_o     (phase),
        .out_vld_o   (vld),
        .coef_o      (coef)
    );

    function automatic longint step_of(input int unsigned r);
        if (r < 8192) return 64'd131072;
        return (64'd1 << 30) / r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sw(input logic [1:0] sel, input logic [HALF_W-1:0] d);
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
        case (sel)
            2'd0: m_waddr = d[7:0];
            2'd1: m_stage = d;
            2'd2: begin
                mem_m[m_waddr] = {d, m_stage};
                m_waddr = m_waddr + 8'd1;
            end
            default: ;
        endcase
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic pix(input logic st, input logic sb, input logic bl, input logic [15:0] r);
        longint s;
        longint sum;
        string  tag;
        ratio = r; start = st; strobe = sb; blank = bl;
        s = step_of(r);
        if (st) begin m_frac = 0; m_adv = 0; m_ph = 0; end
        if (sb) begin
            if (bl) begin
                m_adv = 1; m_ph = 0;
            end else begin
                sum    = m_frac + s;
                m_adv  = int'(sum >> 16);
                m_frac = sum & 64'hFFFF;
                m_ph   = int'(m_frac >> 8);
            end
        end
        if (sb && bl)            tag = "R7 blank";
        else if (st && sb)       tag = "R5 start+strobe";
        else if (st)             tag = "R4 start";
        else if (sb && r < 8192) tag = "R3 clamp";
        else if (sb)             tag = "R2 step";
        else                     tag = "R6 idle";
        @(negedge clk);
        start = 1'b0; strobe = 1'b0; blank = 1'b0;
        check({tag, " adv"},   64'(adv),   64'(m_adv));
        check({tag, " phase"}, 64'(phase), 64'(m_ph));
        check({tag, " vld"},   64'(vld),   64'(sb));
        check("R9 coef row",   64'(coef),  64'(mem_m[m_ph]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [ROW_W-1:0] row_ff;
        logic [ROW_W-1:0] row_00;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) mem_m[i] = '0;

        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 adv in reset",   64'(adv),   0);
        check("R1 phase in reset", 64'(phase), 0);
        check("R1 vld in reset",   64'(vld),   0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 adv after reset",   64'(adv),   0);
        check("R1 phase after reset", 64'(phase), 0);
        check("R1 vld after reset",   64'(vld),   0);

        // R8 fill every row
        sw(2'd0, '0);
        for (int i = 0; i < 256; i++) begin
            sw(2'd1, HALF_W'($urandom));
            sw(2'd2, HALF_W'($urandom));
        end
        @(negedge clk);

        // unit step: adv 1, phase 0
        pix(1, 1, 0, 16'h4000);
        pix(0, 1, 0, 16'h4000);
        // half step: phase 0x80 then advance
        pix(1, 0, 0, 16'h8000);
        for (int i = 0; i < 4; i++) pix(0, 1, 0, 16'h8000);
        // 4/3 step, blank in the middle, idle hold
        pix(1, 1, 0, 16'h3000);
        pix(0, 1, 0, 16'h3000);
        pix(0, 1, 1, 16'h3000);
        pix(0, 0, 0, 16'h3000);
        pix(0, 1, 0, 16'h3000);
        pix(0, 1, 1, 16'h0100);
        // exactly 2.0 and below the limit
        pix(1, 1, 0, 16'h2000);
        pix(0, 1, 0, 16'h1000);
        pix(0, 1, 0, 16'h0000);
        // largest upscale
        pix(1, 1, 0, 16'hFFFF);
        for (int i = 0; i < 3; i++) pix(0, 1, 0, 16'hFFFF);
        // start collides with strobe mid-line
        pix(0, 1, 0, 16'h5555);
        pix(1, 1, 0, 16'h5555);
        pix(1, 1, 1, 16'h5555);

        // R8 address wrap from 255 to 0
        sw(2'd0, HALF_W'(8'hFF));
        sw(2'd1, HALF_W'(20'h12345));
        sw(2'd2, HALF_W'(20'hABCDE));
        sw(2'd1, HALF_W'(20'h0F0F0));
        sw(2'd2, HALF_W'(20'h5A5A5));
        row_ff = {20'hABCDE, 20'h12345};
        row_00 = {20'h5A5A5, 20'h0F0F0};
        // R10 ignored select must not move the address
        sw(2'd3, HALF_W'(20'h00010));
        sw(2'd2, HALF_W'(20'h33333));
        @(negedge clk);
        pix(1, 1, 0, 16'd8193);
        check("R8 wrap row 255 phase", 64'(phase), 64'hFF);
        check("R8 wrap row 255 data",  64'(coef),  64'(row_ff));
        pix(1, 1, 0, 16'h4000);
        check("R8 wrap row 0 data",    64'(coef),  64'(row_00));
        check("R10 row 1 after ignored select", 64'(mem_m[1]), 64'({20'h33333, 20'h0F0F0}));

        // random lines
        begin
            logic [15:0] r_cur;
            r_cur = 16'h4000;
            for (int i = 0; i < 4000; i++) begin
                int unsigned pick;
                pick = $urandom % 100;
                if (pick < 4) begin
                    if (($urandom % 4) == 0) r_cur = 16'($urandom % 8192);
                    else r_cur = 16'(8192 + ($urandom % (65536 - 8192)));
                    pix(1, 1'($urandom), 1'(($urandom % 6) == 0), r_cur);
                end else if (pick < 6) begin
                    sw(2'($urandom % 4), HALF_W'($urandom));
                    @(negedge clk);
                end else begin
                    pix(0, 1'(($urandom % 4) != 0), 1'(($urandom % 10) == 0), r_cur);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule